// File: doc/BRIEF.md
# Debug trigger register bank

This block holds the configuration state of a small set of hardware breakpoint and watchpoint triggers. Software reaches it through a narrow register port: a pointer register chooses which trigger is visible, and two windows then show that trigger's packed control word and its compare value. A fourth window is reserved and always reads zero. The address comparators, the actions taken on a match and trigger chaining are built elsewhere; this bank only stores, filters and packs their settings.

A trigger can be claimed by the debugger through its debug-owner bit. While that bit is set, code outside debug mode cannot change the trigger's control word or compare value. Three summary outputs tell the instruction fetch path, the load path and the store path whether at least one trigger watches that kind of access. The memory pipeline can then skip address comparison when nothing is armed.

Top module: `trig_bank`

## Requirements
- R1: After reset the pointer reads 0, every control word reads 0x2000_0000 (only the type field set), every compare value reads 0, and all three summary outputs are low.
- R2: A pointer write (reg_sel 0) is ignored when the full written value is not below NUM_TRIG. No truncation is applied, so 0x101 is ignored too.
- R3: reg_sel encodes the window: 0 pointer, 1 control word, 2 compare value, 3 reserved. Writes to windows 1 and 2 reach only the trigger the pointer selects. rd_data shows the window chosen by reg_sel in the same cycle, and a write becomes visible from the next cycle.
- R4: Control word layout, with XLEN 32: type [31:28], debug-owner [27], mask capability [26:21], reserved [20], hit [19], timing [18], action [17:12], chain [11], match mode [10:7], M [6], H [5], S [4], U [3], execute [2], store [1], load [0]. Bits [27] and [19:0] are writable and store what is written.
- R5: When the selected trigger's debug-owner bit is 1 and dbg_mode is low, writes to its control word and compare value are dropped. When dbg_mode is high, the same writes take effect.
- R6: A control write with execute (bit 2) set stores timing (bit 18) as 0, whatever was written there.
- R7: The type field always reads 2, the mask capability field always reads 0, and reserved bit 20 reads 0. Writes to these bits have no effect.
- R8: watch_fetch, watch_load and watch_store are the OR over all triggers of the stored execute, load and store bits. They follow a control write from the next cycle.
- R9: The reserved window (reg_sel 3) always reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | Hart is currently in debug mode |
| wr_en | input | 1 | Write strobe for the selected window |
| reg_sel | input | 2 | Window select: 0 pointer, 1 control, 2 compare, 3 reserved |
| wr_data | input | XLEN | Write value |
| rd_data | output | XLEN | Read value of the selected window |
| watch_fetch | output | 1 | Some trigger watches instruction fetch |
| watch_load | output | 1 | Some trigger watches loads |
| watch_store | output | 1 | Some trigger watches stores |

## Verification
The bench first drives directed patterns. An all-ones control write shows the timing override and the read-only masking together, and claims the trigger for the debugger. A later compare write outside debug mode separates a dropped write from an accepted one. The same write repeated with dbg_mode high separates a lock that depends on dbg_mode from one that is permanent. Pointer values 4 and 0x101 separate a full-width range check from a truncating one. A long pseudo-random stream then mixes windows, debug state and data. The bench model compares every window and summary output on every clock, so any error in per-trigger routing or in the OR of the summaries shows up.

// File: rtl/trig_bank.sv
module trig_bank #(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_mode,
  input  logic            wr_en,
  input  logic [1:0]      reg_sel,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_data,
  output logic            watch_fetch,
  output logic            watch_load,
  output logic            watch_store
);
  localparam int SW    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int TY_LO = XLEN - 4;
  localparam int DM_B  = XLEN - 5;
  localparam int TIM_B = 18;
  localparam int EXE_B = 2;
  localparam int STO_B = 1;
  localparam int LD_B  = 0;
  localparam logic [XLEN-1:0] WMASK   = (XLEN'(1) << DM_B) | XLEN'(20'hF_FFFF);
  localparam logic [XLEN-1:0] TY_WORD = XLEN'(2) << TY_LO;

  logic [SW-1:0]                    sel_q;
  logic [NUM_TRIG-1:0][XLEN-1:0]    ctl_q;
  logic [NUM_TRIG-1:0][XLEN-1:0]    cmp_q;
  logic [XLEN-1:0]                  ctl_new;
  logic                             sel_ok;
  logic                             locked;

  assign sel_ok = (32'(sel_q) < NUM_TRIG);
  assign locked = sel_ok && ctl_q[sel_q][DM_B] && !dbg_mode;

  always_comb begin
    ctl_new = wr_data & WMASK;
    if (wr_data[EXE_B]) ctl_new[TIM_B] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      ctl_q <= '0;
      cmp_q <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        2'd0: if (wr_data < XLEN'(NUM_TRIG)) sel_q <= SW'(wr_data);
        2'd1: if (sel_ok && !locked) ctl_q[sel_q] <= ctl_new;
        2'd2: if (sel_ok && !locked) cmp_q[sel_q] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    rd_data = XLEN'(sel_q);
      2'd1:    rd_data = sel_ok ? (ctl_q[sel_q] | TY_WORD) : '0;
      2'd2:    rd_data = sel_ok ? cmp_q[sel_q] : '0;
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    watch_fetch = 1'b0;
    watch_load  = 1'b0;
    watch_store = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      watch_fetch |= ctl_q[i][EXE_B];
      watch_load  |= ctl_q[i][LD_B];
      watch_store |= ctl_q[i][STO_B];
    end
  end
endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk #(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  parameter int SW       = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          dbg_mode,
  input logic                          wr_en,
  input logic [1:0]                    reg_sel,
  input logic [XLEN-1:0]               wr_data,
  input logic [XLEN-1:0]               rd_data,
  input logic                          watch_load,
  input logic [SW-1:0]                 sel_q,
  input logic [NUM_TRIG-1:0][XLEN-1:0] ctl_q,
  input logic [NUM_TRIG-1:0][XLEN-1:0] cmp_q
);
  localparam int DM_B = XLEN - 5;

  a_r2_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_TRIG);

  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0 && wr_data >= XLEN'(NUM_TRIG)) |=> $stable(sel_q));

  a_r5_ctl_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1 && !dbg_mode && ctl_q[sel_q][DM_B]) |=> $stable(ctl_q));

  a_r5_cmp_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2 && !dbg_mode && ctl_q[sel_q][DM_B]) |=> $stable(cmp_q));

  a_r7_type_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd1) |-> (rd_data[XLEN-1:XLEN-4] == 4'd2 && rd_data[XLEN-6:20] == '0));

  a_r9_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> rd_data == '0);

  a_r8_load_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(watch_load) |-> $past(wr_en && reg_sel == 2'd1 && wr_data[0]));

  for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_tim
    a_r6_exec_timing: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[gi][2] |-> !ctl_q[gi][18]);
  end
endmodule

bind trig_bank trig_bank_chk #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .rd_data(rd_data), .watch_load(watch_load),
  .sel_q(sel_q), .ctl_q(ctl_q), .cmp_q(cmp_q));

// File: tb/trig_bank_bench.sv
module trig_bank_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        watch_fetch, watch_load, watch_store;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int unsigned m_ptr;
  logic [31:0] m_ctl [N];
  logic [31:0] m_cmp [N];

  always #10 clk = ~clk;

  trig_bank #(.NUM_TRIG(N), .XLEN(32)) u_trig_bank (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .watch_fetch(watch_fetch),
    .watch_load(watch_load), .watch_store(watch_store));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_read(logic [1:0] w);
    case (w)
      2'd0: return m_ptr;
      2'd1: return 32'h2000_0000 | m_ctl[m_ptr];
      2'd2: return m_cmp[m_ptr];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_ptr = 0;
    for (int i = 0; i < N; i++) begin m_ctl[i] = '0; m_cmp[i] = '0; end
  endtask

  task automatic model_write(bit dbg, logic [1:0] w, logic [31:0] d);
    bit owned;
    logic [31:0] v;
    owned = m_ctl[m_ptr][27] && !dbg;
    if (w == 2'd0) begin
      if (d < N) m_ptr = d;
    end else if (w == 2'd1 && !owned) begin
      v = '0;
      v[27] = d[27];
      v[19:0] = d[19:0];
      if (d[2]) v[18] = 1'b0;
      m_ctl[m_ptr] = v;
    end else if (w == 2'd2 && !owned) begin
      m_cmp[m_ptr] = d;
    end
  endtask

  task automatic compare_all(string req);
    bit ef, el, es;
    ef = 0; el = 0; es = 0;
    for (int i = 0; i < N; i++) begin
      ef |= m_ctl[i][2]; el |= m_ctl[i][0]; es |= m_ctl[i][1];
    end
    check(req, "rd_data", rd_data, expect_read(reg_sel));
    check("R8", "watch_fetch", {31'd0, watch_fetch}, {31'd0, ef});
    check("R8", "watch_load",  {31'd0, watch_load},  {31'd0, el});
    check("R8", "watch_store", {31'd0, watch_store}, {31'd0, es});
  endtask

  task automatic step(string req, bit dbg, bit we, logic [1:0] w, logic [31:0] d);
    @(negedge clk);
    dbg_mode = dbg; wr_en = we; reg_sel = w; wr_data = d;
    #2 compare_all(req);
    @(posedge clk);
    if (we) model_write(dbg, w, d);
  endtask

  task automatic peek(string req, logic [1:0] w);
    step(req, 1'b0, 1'b0, w, 32'h0);
  endtask

  initial begin
    int unsigned seed;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int w = 0; w < 4; w++) peek("R1", 2'(w));
    // R4 R6 R7: all-ones write claims trigger 0 and sets execute
    step("R4", 0, 1, 2'd1, 32'hFFFF_FFFF);
    peek("R6", 2'd1);
    check("R6", "ctl word", rd_data, 32'h280B_FFFF);
    // R5: compare and control writes dropped outside debug mode
    step("R5", 0, 1, 2'd2, 32'hDEAD_BEEF);
    step("R5", 0, 1, 2'd1, 32'h0000_0000);
    peek("R5", 2'd2);
    peek("R5", 2'd1);
    // R2: pointer range filter
    step("R2", 0, 1, 2'd0, 32'd4);
    step("R2", 0, 1, 2'd0, 32'h101);
    peek("R2", 2'd0);
    step("R3", 0, 1, 2'd0, 32'd2);
    step("R3", 0, 1, 2'd1, 32'h0004_0001);
    peek("R3", 2'd1);
    check("R3", "timing kept without execute", rd_data, 32'h2004_0001);
    step("R3", 0, 1, 2'd2, 32'h1234_5678);
    peek("R3", 2'd2);
    // R9: reserved window
    step("R9", 0, 1, 2'd3, 32'hFFFF_FFFF);
    peek("R9", 2'd3);
    // R5: debug mode unlocks trigger 0
    step("R5", 0, 1, 2'd0, 32'd0);
    step("R5", 1, 1, 2'd2, 32'hCAFE_0001);
    step("R5", 1, 1, 2'd1, 32'h0000_0002);
    peek("R5", 2'd2);
    peek("R8", 2'd1);
    // mixed stream
    seed = 32'h1357_9BDF;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d;
      seed = seed * 1103515245 + 12345;
      d = (seed[7:6] == 2'b00) ? {30'd0, seed[17:16]} : {seed[31:8], seed[15:8]};
      step("R3", seed[3], seed[4] | seed[5], seed[1:0], d);
    end
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    for (int w = 0; w < 4; w++) peek("R1", 2'(w));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule